// File: doc/BRIEF.md
# SPI Flash Command and Status Controller

This block is the slave-side command front end of a serial NOR flash. It watches a single-bit SPI link (chip select, serial clock, serial data in), oversamples it in the system clock domain, collects the opcode, an optional status data byte and a 24-bit address, and decides on the rising edge of chip select whether the frame is carried out. It holds the 8-bit status byte: busy flag, write-enable latch, a four-bit protect level and a status-write lock bit. It streams that byte back on the serial output for the status-read opcode.

Program and erase work never reaches an array here. An accepted operation leaves the block as a one-cycle request pulse carrying the address and, for erases, the erase size. An internal counter then stands in for the real operation time. While that counter runs, the busy flag reads 1 and every command other than a status read is refused. When the count ends, the busy flag and the write-enable latch both clear. A status-write lock ties the write-protect pin into status updates, and a sleep mode blocks everything except a wake opcode.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the status byte reads 00h. The serial output enable `soEn` is low whenever no status read is in progress.
- R2: Opcode 06h sets the write-enable latch (status bit 1). Opcode 04h clears it.
- R3: A frame takes effect only if chip select rises on a whole-byte boundary with the exact length its opcode needs: 1 byte for 06h/04h/B9h/60h/C7h, 2 bytes for 01h, 4 bytes for 20h/D8h, and 4 or more bytes for 02h (trailing data bytes are ignored). Any other frame is dropped with no effect.
- R4: Page program (02h + 3 address bytes, MSB first) issues one `progReq` pulse with `reqAddr` equal to the address, but only while the write-enable latch is set.
- R5: Each accepted program, erase or status write sets the busy flag (status bit 0) for a parameterised number of clock cycles. The write-enable latch stays set while the flag is 1. Both clear together when the count ends.
- R6: While the busy flag is set, every opcode except the status read (05h) is ignored.
- R7: Status write (01h + data) needs the write-enable latch. It loads status bits 7 and 5..2 from the data byte and leaves bits 1..0 to the block; bit 6 always reads 0. The write is refused when status bit 7 is 1 and `wpN` is low.
- R8: With protect level L = status bits 5..2 nonzero, the top min(2^(L-1), all) 64 KiB blocks (address bits 23..16) are protected. Program, sector erase and block erase aimed at a protected block are refused, and chip erase is refused whenever L is nonzero.
- R9: Accepted erases issue one `eraseReq` pulse: `eraseKind` 0 for 20h (sector), 1 for D8h (block), 2 for 60h or C7h (chip, `reqAddr` 0). `progReq` and `eraseReq` are never high together.
- R10: After B9h the block sleeps. In that state the status read produces no output and all opcodes except ABh are ignored. ABh (any whole number of bytes) wakes it.
- R11: Input bits are taken on rising serial clock, MSB first. Both clock idle levels (SPI mode 0 and mode 3) work.
- R12: The status read shifts out the current status byte MSB first, repeated byte after byte until chip select rises. Each byte is a fresh sample, so the busy flag can clear inside one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI link |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock |
| si | input | 1 | SPI serial data in |
| wpN | input | 1 | Write-protect pin, active low |
| so | output | 1 | SPI serial data out |
| soEn | output | 1 | Output enable for `so` |
| progReq | output | 1 | One-cycle page program request |
| eraseReq | output | 1 | One-cycle erase request |
| eraseKind | output | 2 | Erase size: 0 sector, 1 block, 2 chip |
| reqAddr | output | 24 | Address carried with a request |

## Verification
SPI inputs pass two synchronizer stages and one edge register. A falling serial clock therefore changes `so` three clock cycles later, and the bench samples `so` five cycles after each fall, just before the next rise. A frame is acted on three to four cycles after chip select rises. The bench waits eight cycles after every frame before it reads the request counters its negative-edge monitor keeps. Busy windows last exactly the configured count after the commit cycle. The bench brackets each window with status reads: one a few hundred cycles after the commit, which must show the flag set, and one past the end, which must show both flags clear. A long single-frame read also shows the flag falling partway through the stream.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CMD_WR_ENABLE  = 8'h06;
  localparam logic [7:0] CMD_WR_DISABLE = 8'h04;
  localparam logic [7:0] CMD_RD_STATUS  = 8'h05;
  localparam logic [7:0] CMD_WR_STATUS  = 8'h01;
  localparam logic [7:0] CMD_PROGRAM    = 8'h02;
  localparam logic [7:0] CMD_ERASE_SECT = 8'h20;
  localparam logic [7:0] CMD_ERASE_BLK  = 8'hD8;
  localparam logic [7:0] CMD_ERASE_ALLA = 8'h60;
  localparam logic [7:0] CMD_ERASE_ALLB = 8'hC7;
  localparam logic [7:0] CMD_SLEEP      = 8'hB9;
  localparam logic [7:0] CMD_WAKE       = 8'hAB;

  localparam logic [1:0] KIND_SECT = 2'd0;
  localparam logic [1:0] KIND_BLK  = 2'd1;
  localparam logic [1:0] KIND_CHIP = 2'd2;

  typedef enum logic [2:0] {
    BUSY_PROG, BUSY_SECT, BUSY_BLK, BUSY_CHIP, BUSY_WRSR
  } busyKindT;

  typedef struct packed {
    logic     setWel;
    logic     clrWel;
    logic     writeSr;
    logic     startBusy;
    busyKindT busyKind;
    logic     enterSleep;
    logic     exitSleep;
    logic     issueProg;
    logic     issueErase;
    logic [1:0] eraseKind;
  } ctrlStrobeT;

endpackage

// File: rtl/flash_cmd_datapath.sv
module flash_cmd_datapath
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int PROG_CYC   = 2000,
  parameter int SECT_CYC   = 5000,
  parameter int BLK_CYC    = 20000,
  parameter int CHIP_CYC   = 100000,
  parameter int WRSR_CYC   = 1000,
  localparam int ADDR_W    = 8 * ADDR_BYTES,
  localparam int BLK_W     = ADDR_W - 16,
  localparam int BC_W      = $clog2(ADDR_BYTES + 3)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              si,
  input  logic              wpN,
  input  ctrlStrobeT        strobe,
  output logic              frameEnd,
  output logic              frameAligned,
  output logic [BC_W-1:0]   frameBytes,
  output logic [7:0]        opcode,
  output logic [BLK_W-1:0]  blkIdx,
  output logic              wpS,
  output logic [7:0]        statusQ,
  output logic              sleepQ,
  output logic              so,
  output logic              soEn,
  output logic              progReq,
  output logic              eraseReq,
  output logic [1:0]        eraseKind,
  output logic [ADDR_W-1:0] reqAddr
);

  localparam int MAX_AB  = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_CD  = (BLK_CYC > CHIP_CYC) ? BLK_CYC : CHIP_CYC;
  localparam int MAX_ABC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int MAX_CYC = (MAX_ABC > WRSR_CYC) ? MAX_ABC : WRSR_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [BC_W-1:0] BYTE_SAT  = '1;
  localparam logic [BC_W-1:0] ADDR_LAST = BC_W'(ADDR_BYTES);
  localparam logic [BC_W-1:0] ONE_BYTE  = BC_W'(1);

  // two-stage synchronizers plus one edge-detect stage
  logic [1:0] csSync, sclkSync, siSync, wpSync;
  logic       csQ, sclkQ;
  logic       csLow, csFall, csRise, sclkRise, sclkFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync   <= 2'b11;
      sclkSync <= 2'b00;
      siSync   <= 2'b00;
      wpSync   <= 2'b11;
      csQ      <= 1'b1;
      sclkQ    <= 1'b0;
    end else begin
      csSync   <= {csSync[0], csN};
      sclkSync <= {sclkSync[0], sclk};
      siSync   <= {siSync[0], si};
      wpSync   <= {wpSync[0], wpN};
      csQ      <= csSync[1];
      sclkQ    <= sclkSync[1];
    end
  end

  assign csLow    = ~csSync[1];
  assign csFall   = csQ & ~csSync[1];
  assign csRise   = ~csQ & csSync[1];
  assign sclkRise = csLow & ~sclkQ & sclkSync[1];
  assign sclkFall = csLow & sclkQ & ~sclkSync[1];
  assign wpS      = wpSync[1];
  assign frameEnd = csRise;

  // input shifter and frame fields
  logic [6:0]        shiftQ;
  logic [2:0]        bitIdx;
  logic [BC_W-1:0]   byteCnt;
  logic [7:0]        opcodeQ, srDataQ;
  logic [ADDR_W-1:0] addrQ;
  logic              rdMode;
  logic [7:0]        newByte;

  assign newByte = {shiftQ, siSync[1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '0;
      bitIdx  <= '0;
      byteCnt <= '0;
      opcodeQ <= '0;
      srDataQ <= '0;
      addrQ   <= '0;
      rdMode  <= 1'b0;
    end else if (csFall) begin
      bitIdx  <= '0;
      byteCnt <= '0;
      rdMode  <= 1'b0;
    end else if (csRise) begin
      rdMode  <= 1'b0;
    end else if (sclkRise) begin
      shiftQ <= newByte[6:0];
      bitIdx <= bitIdx + 3'd1;
      if (bitIdx == 3'd7) begin
        if (byteCnt != BYTE_SAT) byteCnt <= byteCnt + ONE_BYTE;
        if (byteCnt == '0) begin
          opcodeQ <= newByte;
          rdMode  <= (newByte == CMD_RD_STATUS) && !sleepQ;
        end
        if (byteCnt == ONE_BYTE) srDataQ <= newByte;
        if (byteCnt != '0 && byteCnt <= ADDR_LAST)
          addrQ <= {addrQ[ADDR_W-9:0], newByte};
      end
    end
  end

  assign frameAligned = (bitIdx == 3'd0);
  assign frameBytes   = byteCnt;
  assign opcode       = opcodeQ;
  assign blkIdx       = addrQ[ADDR_W-1:16];

  // status register and busy timer
  logic             wipQ, welQ, srwdQ;
  logic [3:0]       bpQ;
  logic [CNT_W-1:0] busyCnt, busyLen;

  always_comb begin
    case (strobe.busyKind)
      BUSY_PROG: busyLen = CNT_W'(PROG_CYC);
      BUSY_SECT: busyLen = CNT_W'(SECT_CYC);
      BUSY_BLK:  busyLen = CNT_W'(BLK_CYC);
      BUSY_CHIP: busyLen = CNT_W'(CHIP_CYC);
      default:   busyLen = CNT_W'(WRSR_CYC);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wipQ    <= 1'b0;
      welQ    <= 1'b0;
      srwdQ   <= 1'b0;
      bpQ     <= '0;
      busyCnt <= '0;
      sleepQ  <= 1'b0;
    end else begin
      if (strobe.setWel) welQ <= 1'b1;
      if (strobe.clrWel) welQ <= 1'b0;
      if (strobe.writeSr) begin
        srwdQ <= srDataQ[7];
        bpQ   <= srDataQ[5:2];
      end
      if (strobe.enterSleep) sleepQ <= 1'b1;
      if (strobe.exitSleep)  sleepQ <= 1'b0;
      if (strobe.startBusy) begin
        wipQ    <= 1'b1;
        busyCnt <= busyLen;
      end else if (wipQ) begin
        if (busyCnt <= CNT_W'(1)) begin
          wipQ    <= 1'b0;
          welQ    <= 1'b0;
          busyCnt <= '0;
        end else begin
          busyCnt <= busyCnt - CNT_W'(1);
        end
      end
    end
  end

  assign statusQ = {srwdQ, 1'b0, bpQ, welQ, wipQ};

  // request outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progReq   <= 1'b0;
      eraseReq  <= 1'b0;
      eraseKind <= '0;
      reqAddr   <= '0;
    end else begin
      progReq  <= strobe.issueProg;
      eraseReq <= strobe.issueErase;
      if (strobe.issueProg || strobe.issueErase) begin
        eraseKind <= strobe.eraseKind;
        reqAddr   <= (strobe.issueErase && strobe.eraseKind == KIND_CHIP) ? '0 : addrQ;
      end
    end
  end

  // status streaming, one fresh sample per byte
  logic [7:0] snapQ;
  logic [2:0] outIdx;
  logic       soQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapQ  <= '0;
      outIdx <= 3'd7;
      soQ    <= 1'b0;
    end else if (csFall) begin
      outIdx <= 3'd7;
      soQ    <= 1'b0;
    end else if (sclkFall && rdMode) begin
      if (outIdx == 3'd7) begin
        snapQ <= statusQ;
        soQ   <= statusQ[7];
      end else begin
        soQ   <= snapQ[outIdx];
      end
      outIdx <= outIdx - 3'd1;
    end
  end

  assign so   = soQ;
  assign soEn = rdMode & csLow;

endmodule

// File: rtl/flash_cmd_control.sv
module flash_cmd_control
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  localparam int ADDR_W    = 8 * ADDR_BYTES,
  localparam int BLK_W     = ADDR_W - 16,
  localparam int BC_W      = $clog2(ADDR_BYTES + 3)
) (
  input  logic             frameEnd,
  input  logic             frameAligned,
  input  logic [BC_W-1:0]  frameBytes,
  input  logic [7:0]       opcode,
  input  logic [BLK_W-1:0] blkIdx,
  input  logic             wpS,
  input  logic             wip,
  input  logic             wel,
  input  logic             srwd,
  input  logic [3:0]       bp,
  input  logic             sleepQ,
  output ctrlStrobeT       strobe
);

  localparam logic [BC_W-1:0] LEN_ONE  = BC_W'(1);
  localparam logic [BC_W-1:0] LEN_TWO  = BC_W'(2);
  localparam logic [BC_W-1:0] LEN_ADDR = BC_W'(ADDR_BYTES + 1);
  localparam logic [BLK_W:0]  NUM_BLK  = {1'b1, {BLK_W{1'b0}}};

  // protected region: the top min(2^(L-1), all) blocks
  logic [BLK_W:0] protCnt;
  logic           protHit;

  always_comb begin
    if (bp == 4'd0)
      protCnt = '0;
    else if (int'(bp) - 1 >= BLK_W)
      protCnt = NUM_BLK;
    else
      protCnt = {{BLK_W{1'b0}}, 1'b1} << (bp - 4'd1);
  end

  assign protHit = ({1'b0, blkIdx} >= (NUM_BLK - protCnt));

  logic live;
  assign live = frameEnd && frameAligned && !wip && (frameBytes != '0);

  always_comb begin
    strobe = '0;
    strobe.busyKind = BUSY_PROG;
    if (live) begin
      if (sleepQ) begin
        if (opcode == CMD_WAKE) strobe.exitSleep = 1'b1;
      end else begin
        case (opcode)
          CMD_WR_ENABLE:  if (frameBytes == LEN_ONE) strobe.setWel = 1'b1;
          CMD_WR_DISABLE: if (frameBytes == LEN_ONE) strobe.clrWel = 1'b1;
          CMD_SLEEP:      if (frameBytes == LEN_ONE) strobe.enterSleep = 1'b1;
          CMD_WR_STATUS:
            if (frameBytes == LEN_TWO && wel && !(srwd && !wpS)) begin
              strobe.writeSr   = 1'b1;
              strobe.startBusy = 1'b1;
              strobe.busyKind  = BUSY_WRSR;
            end
          CMD_PROGRAM:
            if (frameBytes >= LEN_ADDR && wel && !protHit) begin
              strobe.issueProg = 1'b1;
              strobe.startBusy = 1'b1;
              strobe.busyKind  = BUSY_PROG;
            end
          CMD_ERASE_SECT:
            if (frameBytes == LEN_ADDR && wel && !protHit) begin
              strobe.issueErase = 1'b1;
              strobe.eraseKind  = KIND_SECT;
              strobe.startBusy  = 1'b1;
              strobe.busyKind   = BUSY_SECT;
            end
          CMD_ERASE_BLK:
            if (frameBytes == LEN_ADDR && wel && !protHit) begin
              strobe.issueErase = 1'b1;
              strobe.eraseKind  = KIND_BLK;
              strobe.startBusy  = 1'b1;
              strobe.busyKind   = BUSY_BLK;
            end
          CMD_ERASE_ALLA, CMD_ERASE_ALLB:
            if (frameBytes == LEN_ONE && wel && bp == 4'd0) begin
              strobe.issueErase = 1'b1;
              strobe.eraseKind  = KIND_CHIP;
              strobe.startBusy  = 1'b1;
              strobe.busyKind   = BUSY_CHIP;
            end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int PROG_CYC   = 2000,
  parameter int SECT_CYC   = 5000,
  parameter int BLK_CYC    = 20000,
  parameter int CHIP_CYC   = 100000,
  parameter int WRSR_CYC   = 1000,
  localparam int ADDR_W    = 8 * ADDR_BYTES,
  localparam int BLK_W     = ADDR_W - 16,
  localparam int BC_W      = $clog2(ADDR_BYTES + 3)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              si,
  input  logic              wpN,
  output logic              so,
  output logic              soEn,
  output logic              progReq,
  output logic              eraseReq,
  output logic [1:0]        eraseKind,
  output logic [ADDR_W-1:0] reqAddr
);

  ctrlStrobeT       strobe;
  logic             frameEnd, frameAligned, wpS, sleepQ;
  logic [BC_W-1:0]  frameBytes;
  logic [7:0]       opcode, statusQ;
  logic [BLK_W-1:0] blkIdx;

  flash_cmd_datapath #(
    .ADDR_BYTES(ADDR_BYTES), .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC),
    .BLK_CYC(BLK_CYC), .CHIP_CYC(CHIP_CYC), .WRSR_CYC(WRSR_CYC)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .si(si), .wpN(wpN),
    .strobe(strobe), .frameEnd(frameEnd), .frameAligned(frameAligned),
    .frameBytes(frameBytes), .opcode(opcode), .blkIdx(blkIdx), .wpS(wpS),
    .statusQ(statusQ), .sleepQ(sleepQ), .so(so), .soEn(soEn),
    .progReq(progReq), .eraseReq(eraseReq), .eraseKind(eraseKind),
    .reqAddr(reqAddr)
  );

  flash_cmd_control #(.ADDR_BYTES(ADDR_BYTES)) control_i (
    .frameEnd(frameEnd), .frameAligned(frameAligned), .frameBytes(frameBytes),
    .opcode(opcode), .blkIdx(blkIdx), .wpS(wpS), .wip(statusQ[0]),
    .wel(statusQ[1]), .srwd(statusQ[7]), .bp(statusQ[5:2]), .sleepQ(sleepQ),
    .strobe(strobe)
  );

endmodule

// File: rtl/flash_cmd_ctrl_checker.sv
module flash_cmd_ctrl_checker (
  input logic clk,
  input logic rstN,
  input logic progReq,
  input logic eraseReq,
  input logic wip,
  input logic wel,
  input logic sleepQ
);

  // R9: one request kind at a time
  assert_single_request_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progReq, eraseReq}));

  // R5: a request comes out together with busy and a held write-enable latch
  assert_request_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (progReq || eraseReq) |-> (wip && wel));

  // R5: busy ending leaves the latch clear
  assert_busy_end_clears_wel_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> !wel);

  // R4: busy only starts out of a set latch
  assert_busy_needs_wel_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> $past(wel));

  // R6: the latch cannot be set while busy
  assert_no_wel_while_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wel) |-> !$past(wip));

  // R10: sleeping blocks all requests
  assert_no_request_asleep_R10: assert property (@(posedge clk) disable iff (!rstN)
    sleepQ |-> !(progReq || eraseReq));

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_checker checker_i (
  .clk(clk), .rstN(rstN), .progReq(progReq), .eraseReq(eraseReq),
  .wip(statusQ[0]), .wel(statusQ[1]), .sleepQ(sleepQ)
);

// File: tb/flash_cmd_ctrl_tb_top.sv
module flash_cmd_ctrl_tb_top;

  localparam int H     = 5;
  localparam int PROG  = 1200;
  localparam int SECT  = 700;
  localparam int BLK   = 800;
  localparam int CHIP  = 900;
  localparam int WRSR  = 300;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0, csN = 1'b1, sclk = 1'b0, si = 1'b0, wpN = 1'b1;
  logic so, soEn, progReq, eraseReq;
  logic [1:0]  eraseKind;
  logic [23:0] reqAddr;

  flash_cmd_ctrl #(
    .ADDR_BYTES(3), .PROG_CYC(PROG), .SECT_CYC(SECT), .BLK_CYC(BLK),
    .CHIP_CYC(CHIP), .WRSR_CYC(WRSR)
  ) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .si(si), .wpN(wpN),
    .so(so), .soEn(soEn), .progReq(progReq), .eraseReq(eraseReq),
    .eraseKind(eraseKind), .reqAddr(reqAddr)
  );

  int checks = 0, failures = 0;
  int progCnt = 0, eraseCnt = 0;
  logic [23:0] lastAddr = '0;
  logic [1:0]  lastKind = '0;
  logic [7:0]  txBuf [12];
  logic [7:0]  rxBuf [12];
  logic        soEnAny;
  bit          done = 0;

  always @(negedge clk) begin
    if (progReq) begin progCnt++; lastAddr = reqAddr; end
    if (eraseReq) begin eraseCnt++; lastAddr = reqAddr; lastKind = eraseKind; end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runFrame(input int nBytes, input int extraBits, input bit mode3);
    soEnAny = 1'b0;
    sclk = mode3; waitClk(4);
    csN = 1'b0; waitClk(4);
    for (int i = 0; i < nBytes; i++) begin
      for (int j = 7; j >= 0; j--) begin
        sclk = 1'b0; si = txBuf[i][j]; waitClk(H);
        rxBuf[i][j] = so; soEnAny = soEnAny | soEn;
        sclk = 1'b1; waitClk(H);
      end
    end
    for (int k = 0; k < extraBits; k++) begin
      sclk = 1'b0; si = 1'b0; waitClk(H);
      sclk = 1'b1; waitClk(H);
    end
    if (!mode3) sclk = 1'b0;
    waitClk(4); csN = 1'b1; waitClk(8);
  endtask

  task automatic cmd1(input logic [7:0] op);
    txBuf[0] = op; runFrame(1, 0, 0);
  endtask

  task automatic cmdAddr(input logic [7:0] op, input logic [23:0] a, input int dataBytes);
    txBuf[0] = op; txBuf[1] = a[23:16]; txBuf[2] = a[15:8]; txBuf[3] = a[7:0];
    for (int i = 4; i < 4 + dataBytes; i++) txBuf[i] = 8'h5A;
    runFrame(4 + dataBytes, 0, 0);
  endtask

  task automatic readStat(input int n, input bit mode3);
    txBuf[0] = 8'h05;
    for (int i = 1; i <= n; i++) txBuf[i] = 8'h00;
    runFrame(1 + n, 0, mode3);
  endtask

  task automatic writeStatus(input logic [7:0] v);
    cmd1(8'h06);
    txBuf[0] = 8'h01; txBuf[1] = v; runFrame(2, 0, 0);
    waitClk(WRSR + 40);
  endtask

  function automatic bit isProt(input int lvl, input int blk);
    int cnt;
    if (lvl == 0) return 1'b0;
    cnt = (lvl - 1 >= 8) ? 256 : (1 << (lvl - 1));
    return blk >= 256 - cnt;
  endfunction

  initial begin
    int p0, e0;
    int lv [7] = '{0, 1, 5, 6, 8, 9, 15};
    int bk [5] = '{0, 127, 128, 224, 255};
    waitClk(5); rstN = 1'b1; waitClk(5);

    // R1 reset state
    check("R1 soEn idle", 32'(soEn), 0);
    readStat(1, 0);
    check("R1 reset status", 32'(rxBuf[1]), 32'h00);

    // R2 latch set/clear
    cmd1(8'h06); readStat(1, 0);
    check("R2 wren", 32'(rxBuf[1]), 32'h02);
    cmd1(8'h04); readStat(1, 0);
    check("R2 wrdi", 32'(rxBuf[1]), 32'h00);

    // R3 frame length and alignment
    txBuf[0] = 8'h06; runFrame(1, 3, 0); readStat(1, 0);
    check("R3 misaligned", 32'(rxBuf[1]), 32'h00);
    txBuf[0] = 8'h06; txBuf[1] = 8'h00; runFrame(2, 0, 0); readStat(1, 0);
    check("R3 long wren", 32'(rxBuf[1]), 32'h00);
    cmd1(8'h06); p0 = progCnt;
    txBuf[0] = 8'h02; txBuf[1] = 8'h01; txBuf[2] = 8'h02; runFrame(3, 0, 0);
    check("R3 short program", 32'(progCnt - p0), 0);
    cmd1(8'h04);

    // R4 program gating
    p0 = progCnt; cmdAddr(8'h02, 24'h001234, 0);
    check("R4 no latch", 32'(progCnt - p0), 0);
    cmd1(8'h06); p0 = progCnt; cmdAddr(8'h02, 24'h0A55C3, 2);
    check("R4 program issued", 32'(progCnt - p0), 1);
    check("R4 program addr", 32'(lastAddr), 32'h0A55C3);

    // R5 / R12 busy visible and repeated stream
    readStat(2, 0);
    check("R5 busy set", 32'(rxBuf[1]), 32'h03);
    check("R12 repeat", 32'(rxBuf[2]), 32'h03);
    // R6 ignored while busy
    cmd1(8'h04); p0 = progCnt; cmdAddr(8'h02, 24'h000100, 0);
    check("R6 program while busy", 32'(progCnt - p0), 0);
    readStat(10, 0);
    check("R6 wrdi ignored", 32'(rxBuf[1]), 32'h03);
    check("R12 clears in frame", 32'(rxBuf[10]), 32'h00);
    waitClk(PROG); readStat(1, 0);
    check("R5 done", 32'(rxBuf[1]), 32'h00);

    // R7 status write and lock
    writeStatus(8'hFF); readStat(1, 0);
    check("R7 write", 32'(rxBuf[1]), 32'hBC);
    wpN = 1'b0; cmd1(8'h06);
    txBuf[0] = 8'h01; txBuf[1] = 8'h00; runFrame(2, 0, 0); waitClk(WRSR + 40);
    readStat(1, 0);
    check("R7 locked", 32'(rxBuf[1]), 32'hBE);
    wpN = 1'b1;
    txBuf[0] = 8'h01; txBuf[1] = 8'h00; runFrame(2, 0, 0); waitClk(WRSR + 40);
    readStat(1, 0);
    check("R7 unlocked", 32'(rxBuf[1]), 32'h00);

    // R8 protection sweep for program
    foreach (lv[i]) begin
      writeStatus(8'(lv[i] << 2));
      foreach (bk[j]) begin
        bit exp;
        exp = !isProt(lv[i], bk[j]);
        cmd1(8'h06); p0 = progCnt;
        cmdAddr(8'h02, {8'(bk[j]), 16'h0100}, 1);
        check($sformatf("R8 lvl %0d blk %0d", lv[i], bk[j]), 32'(progCnt - p0), 32'(exp));
        if (exp) waitClk(PROG + 40); else cmd1(8'h04);
      end
    end

    // R8 / R9 erases under protect level 6
    writeStatus(8'h18);
    cmd1(8'h06); e0 = eraseCnt; cmdAddr(8'hD8, 24'hE00000, 0);
    check("R8 block erase protected", 32'(eraseCnt - e0), 0);
    cmd1(8'h04);
    cmd1(8'h06); e0 = eraseCnt; cmdAddr(8'hD8, 24'hDF0000, 0);
    check("R9 block erase", 32'(eraseCnt - e0), 1);
    check("R9 block kind", 32'(lastKind), 1);
    check("R9 block addr", 32'(lastAddr), 32'hDF0000);
    waitClk(BLK + 40);
    cmd1(8'h06); e0 = eraseCnt; cmdAddr(8'h20, 24'h003456, 0);
    check("R9 sector kind", 32'({eraseCnt - e0, 2'b00} | 32'(lastKind)), 32'h4);
    check("R9 sector addr", 32'(lastAddr), 32'h003456);
    waitClk(SECT + 40);
    cmd1(8'h06); e0 = eraseCnt; cmd1(8'h60);
    check("R8 chip erase protected", 32'(eraseCnt - e0), 0);
    cmd1(8'h04);
    writeStatus(8'h00);
    cmd1(8'h06); e0 = eraseCnt; cmd1(8'h60);
    check("R9 chip 60", 32'({eraseCnt - e0, 2'b00} | 32'(lastKind)), 32'h6);
    check("R9 chip addr", 32'(lastAddr), 0);
    waitClk(CHIP + 40);
    cmd1(8'h06); e0 = eraseCnt; cmd1(8'hC7);
    check("R9 chip C7", 32'({eraseCnt - e0, 2'b00} | 32'(lastKind)), 32'h6);
    waitClk(CHIP + 40);

    // R10 sleep
    cmd1(8'hB9); readStat(1, 0);
    check("R10 silent read", 32'(soEnAny), 0);
    cmd1(8'h06); cmd1(8'hAB); readStat(1, 0);
    check("R10 wake output", 32'(soEnAny), 1);
    check("R10 wren ignored", 32'(rxBuf[1]), 32'h00);

    // R11 mode 3
    txBuf[0] = 8'h06; runFrame(1, 0, 1); readStat(1, 1);
    check("R11 mode3", 32'(rxBuf[1]), 32'h02);
    cmd1(8'h04); readStat(1, 0);
    check("R11 back to mode0", 32'(rxBuf[1]), 32'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule